// File: doc/BRIEF.md
# Latched Address Port Mux

This block is an eight-pin port. Each pin can be set on its own to one of two jobs. It can be a general-purpose I/O pin, driven from an output-data register and a direction register. It can also carry one bit of the CPU address, taken from an 8032-style bus in which the low address byte and the data share the same lines. The CPU sets a pin's job through a mode register. Clearing a mode bit returns the pin to I/O. Setting it makes the pin drive its address bit and forces the pin's output enable on.

The low address byte is taken from the shared AD lines when the address-latch strobe falls. The high address byte is captured at the same moment. It then stays unchanged until the next falling edge of the strobe. A static configuration input, `high_byte_sel`, selects which byte appears on the port, so pin n shows either address bit n or address bit n+8. All port state sits in a small register window. The mode register is at offset 3, the output data at offset 0 and the direction at offset 1. A pin-level pad model is not part of this block.

Top module: `addr_port_mux`

## Requirements
- R1: After reset the mode, output-data and direction registers all read 00h, so `pin_oe` and `pin_out` are both zero.
- R2: A write to offset 3 loads the mode register, and a read at offset 3 returns the value last written there.
- R3: A write to any offset other than 3 leaves the mode register unchanged. Offset 0 holds the output data and offset 1 holds the direction. Offset 2 is unused: writes to it are dropped and reads of it return 0.
- R4: A pin whose mode bit is 0 drives its output-data bit on `pin_out`, and its direction bit on `pin_oe` (1 = output).
- R5: A pin n whose mode bit is 1 drives latched address bit n on `pin_out` when `high_byte_sel` is 0.
- R6: A pin n whose mode bit is 1 drives latched address bit n+8 (the captured `addr_hi` bit n) when `high_byte_sel` is 1.
- R7: A pin whose mode bit is 1 has `pin_oe` high, whatever its direction bit holds.
- R8: At the first clock edge where `ale` is seen low after being high, the address latch loads `ad_bus` and `addr_hi`. The new value shows from that edge on and is held through every later cycle until the next falling edge of `ale`, including cycles in which `ale` is high.
- R9: The output-data and direction registers keep their contents while a pin is in address mode, and they drive the pin again as soon as its mode bit is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write offset |
| reg_wr_data | input | 8 | Register write data |
| reg_rd_addr | input | 4 | Register read offset |
| reg_rd_data | output | 8 | Register read data (combinational) |
| ale | input | 1 | Address latch strobe from the CPU bus |
| ad_bus | input | 8 | Shared address/data lines (low address byte) |
| addr_hi | input | 8 | High address byte from the CPU |
| high_byte_sel | input | 1 | 1 = port shows A8..A15, 0 = A0..A7 |
| pin_out | output | 8 | Per-pin output value |
| pin_oe | output | 8 | Per-pin output enable |

## Verification
A corrupted mode bit shows on that pin's `pin_oe` and `pin_out` in the same cycle. It also appears in the readback of offset 3 straight after the write that should have set it. A latch that loads on the wrong strobe edge, or that drifts while `ale` is quiet, gives a wrong address bit on every address-mode pin. This can be seen from the clock edge that follows the stray load. The bench also holds `ale` high across several cycles while it changes `ad_bus`. A lost output-data or direction value stays invisible while its pin is in address mode. It shows at the ports in the first cycle after that mode bit is cleared, so the bench clears the mode bit and compares there.

// File: rtl/apm_pkg.sv
package apm_pkg;
   typedef enum logic [1:0] {SEL_NONE, SEL_DATA, SEL_DIR, SEL_MODE} apm_sel_e;
endpackage

// File: rtl/apm_regs.sv
module apm_regs
   import apm_pkg::*;
#(
   parameter int W        = 8,
   parameter int AW       = 4,
   parameter int OFS_DATA = 0,
   parameter int OFS_DIR  = 1,
   parameter int OFS_MODE = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [W-1:0]  wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [W-1:0]  rd_data,
   output logic [W-1:0]  gpio_do,
   output logic [W-1:0]  gpio_dir,
   output logic [W-1:0]  mode
);
   if (OFS_DATA == OFS_DIR || OFS_DATA == OFS_MODE || OFS_DIR == OFS_MODE) begin : g_bad_ofs
      $error("apm_regs: register offsets must differ");
   end
   if (OFS_MODE >= (1 << AW) || OFS_DATA >= (1 << AW) || OFS_DIR >= (1 << AW)) begin : g_bad_aw
      $error("apm_regs: offset outside the window");
   end

   function automatic apm_sel_e decode(input logic [AW-1:0] a);
      if (a == AW'(OFS_MODE))      return SEL_MODE;
      else if (a == AW'(OFS_DATA)) return SEL_DATA;
      else if (a == AW'(OFS_DIR))  return SEL_DIR;
      else                         return SEL_NONE;
   endfunction

   apm_sel_e sel_w, sel_r;
   assign sel_w = decode(wr_addr);
   assign sel_r = decode(rd_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gpio_do  <= '0;
         gpio_dir <= '0;
         mode     <= '0;
      end else if (wr_en) begin
         case (sel_w)
            SEL_DATA: gpio_do  <= wr_data;
            SEL_DIR:  gpio_dir <= wr_data;
            SEL_MODE: mode     <= wr_data;
            default:  ;
         endcase
      end
   end

   always_comb begin
      case (sel_r)
         SEL_DATA: rd_data = gpio_do;
         SEL_DIR:  rd_data = gpio_dir;
         SEL_MODE: rd_data = mode;
         default:  rd_data = '0;
      endcase
   end
endmodule

// File: rtl/apm_addr_latch.sv
module apm_addr_latch #(
   parameter int W          = 8,
   parameter bit HI_CAPTURE = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         ale,
   input  logic [W-1:0] ad_lo,
   input  logic [W-1:0] ad_hi,
   output logic [W-1:0] lat_lo,
   output logic [W-1:0] lat_hi
);
   logic ale_q;
   logic ale_fall;

   assign ale_fall = ale_q & ~ale;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ale_q  <= 1'b0;
         lat_lo <= '0;
      end else begin
         ale_q <= ale;
         if (ale_fall) lat_lo <= ad_lo;
      end
   end

   if (HI_CAPTURE) begin : g_hi_latched
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        lat_hi <= '0;
         else if (ale_fall) lat_hi <= ad_hi;
      end
   end else begin : g_hi_live
      assign lat_hi = ad_hi;
   end
endmodule

// File: rtl/apm_pin_mux.sv
module apm_pin_mux #(
   parameter int W = 8
) (
   input  logic         hi_sel,
   input  logic [W-1:0] mode,
   input  logic [W-1:0] gpio_do,
   input  logic [W-1:0] gpio_dir,
   input  logic [W-1:0] lat_lo,
   input  logic [W-1:0] lat_hi,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe
);
   for (genvar i = 0; i < W; i++) begin : g_pin
      logic addr_bit;
      assign addr_bit   = hi_sel ? lat_hi[i] : lat_lo[i];
      assign pin_out[i] = mode[i] ? addr_bit : gpio_do[i];
      assign pin_oe[i]  = mode[i] | gpio_dir[i];
   end
endmodule

// File: rtl/addr_port_mux.sv
module addr_port_mux #(
   parameter int W          = 8,
   parameter int AW         = 4,
   parameter int OFS_DATA   = 0,
   parameter int OFS_DIR    = 1,
   parameter int OFS_MODE   = 3,
   parameter bit HI_CAPTURE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_wr_en,
   input  logic [AW-1:0] reg_wr_addr,
   input  logic [W-1:0]  reg_wr_data,
   input  logic [AW-1:0] reg_rd_addr,
   output logic [W-1:0]  reg_rd_data,
   input  logic          ale,
   input  logic [W-1:0]  ad_bus,
   input  logic [W-1:0]  addr_hi,
   input  logic          high_byte_sel,
   output logic [W-1:0]  pin_out,
   output logic [W-1:0]  pin_oe
);
   if (W < 1 || W > 32) begin : g_bad_w
      $error("addr_port_mux: W out of range");
   end

   logic [W-1:0] gpio_do, gpio_dir, mode, lat_lo, lat_hi;

   apm_regs #(
      .W(W), .AW(AW), .OFS_DATA(OFS_DATA), .OFS_DIR(OFS_DIR), .OFS_MODE(OFS_MODE)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
      .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
      .gpio_do(gpio_do), .gpio_dir(gpio_dir), .mode(mode)
   );

   apm_addr_latch #(.W(W), .HI_CAPTURE(HI_CAPTURE)) u_latch (
      .clk(clk), .rst_n(rst_n), .ale(ale),
      .ad_lo(ad_bus), .ad_hi(addr_hi),
      .lat_lo(lat_lo), .lat_hi(lat_hi)
   );

   apm_pin_mux #(.W(W)) u_mux (
      .hi_sel(high_byte_sel), .mode(mode),
      .gpio_do(gpio_do), .gpio_dir(gpio_dir),
      .lat_lo(lat_lo), .lat_hi(lat_hi),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );
endmodule

// File: rtl/addr_port_mux_chk.sv
module addr_port_mux_chk #(
   parameter int W        = 8,
   parameter int AW       = 4,
   parameter int OFS_DATA = 0,
   parameter int OFS_DIR  = 1,
   parameter int OFS_MODE = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          reg_wr_en,
   input logic [AW-1:0] reg_wr_addr,
   input logic [W-1:0]  reg_wr_data,
   input logic          ale,
   input logic [W-1:0]  ad_bus,
   input logic          high_byte_sel,
   input logic [W-1:0]  mode,
   input logic [W-1:0]  gpio_do,
   input logic [W-1:0]  gpio_dir,
   input logic [W-1:0]  lat_lo,
   input logic [W-1:0]  pin_out,
   input logic [W-1:0]  pin_oe
);
   // R2
   a_r2_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr_en && reg_wr_addr == AW'(OFS_MODE)) |=> mode == $past(reg_wr_data));
   // R3
   a_r3_other_ofs_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_wr_addr == AW'(OFS_MODE)) |=> $stable(mode));
   // R5
   a_r5_low_byte_on_pins: assert property (@(posedge clk) disable iff (!rst_n)
      !high_byte_sel |-> ((pin_out ^ lat_lo) & mode) == '0);
   // R7
   a_r7_addr_pins_driven: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_oe & mode) == mode);
   // R8
   a_r8_capture_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ale) |=> lat_lo == $past(ad_bus));
   a_r8_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
      !$fell(ale) |=> $stable(lat_lo));
   // R9
   a_r9_data_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_wr_addr == AW'(OFS_DATA)) |=> $stable(gpio_do));
   a_r9_dir_kept: assert property (@(posedge clk) disable iff (!rst_n)
      !(reg_wr_en && reg_wr_addr == AW'(OFS_DIR)) |=> $stable(gpio_dir));
endmodule

bind addr_port_mux addr_port_mux_chk #(
   .W(W), .AW(AW), .OFS_DATA(OFS_DATA), .OFS_DIR(OFS_DIR), .OFS_MODE(OFS_MODE)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr),
   .reg_wr_data(reg_wr_data), .ale(ale), .ad_bus(ad_bus), .high_byte_sel(high_byte_sel),
   .mode(mode), .gpio_do(gpio_do), .gpio_dir(gpio_dir), .lat_lo(lat_lo),
   .pin_out(pin_out), .pin_oe(pin_oe)
);

// File: tb/addr_port_mux_tb.sv
module addr_port_mux_tb;
   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [3:0] reg_wr_addr = '0;
   logic [7:0] reg_wr_data = '0;
   logic [3:0] reg_rd_addr = '0;
   logic [7:0] reg_rd_data;
   logic       ale = 1'b0;
   logic [7:0] ad_bus = '0;
   logic [7:0] addr_hi = '0;
   logic       high_byte_sel = 1'b0;
   logic [7:0] pin_out, pin_oe;

   int n_vec = 0;
   int n_bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   addr_port_mux u_dut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
      .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
      .ale(ale), .ad_bus(ad_bus), .addr_hi(addr_hi), .high_byte_sel(high_byte_sel),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %02h expected %02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      reg_rd_addr = a;
      #1;
      d = reg_rd_data;
   endtask

   // one strobe: high with junk, falls with the real address, then junk again
   task automatic bus_cycle(input logic [7:0] lo, input logic [7:0] hi);
      @(negedge clk);
      ale = 1'b1; ad_bus = ~lo; addr_hi = ~hi;
      @(negedge clk);
      ale = 1'b0; ad_bus = lo; addr_hi = hi;
      @(negedge clk);
      ad_bus = 8'h5A ^ lo; addr_hi = 8'hC3 ^ hi;
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R1 pin_oe", pin_oe, 8'h00);
      check("R1 pin_out", pin_out, 8'h00);
      rd(4'd3, d); check("R1 mode", d, 8'h00);
      rd(4'd0, d); check("R1 data", d, 8'h00);
      rd(4'd1, d); check("R1 dir", d, 8'h00);
   endtask

   task automatic t_regs();
      logic [7:0] d;
      wr(4'd3, 8'hA5);
      rd(4'd3, d); check("R2 mode readback", d, 8'hA5);
      wr(4'd0, 8'h11); wr(4'd1, 8'h22); wr(4'd2, 8'h33); wr(4'd9, 8'h44);
      rd(4'd3, d); check("R3 mode unchanged", d, 8'hA5);
      rd(4'd2, d); check("R3 unused offset reads 0", d, 8'h00);
      rd(4'd0, d); check("R3 data offset", d, 8'h11);
      rd(4'd1, d); check("R3 dir offset", d, 8'h22);
      wr(4'd3, 8'h00);
   endtask

   task automatic t_gpio();
      wr(4'd0, 8'hC6); wr(4'd1, 8'h0F);
      check("R4 gpio out", pin_out, 8'hC6);
      check("R4 gpio oe", pin_oe, 8'h0F);
   endtask

   task automatic t_addr_low();
      high_byte_sel = 1'b0;
      bus_cycle(8'h3C, 8'h9E);
      wr(4'd3, 8'hF0);
      check("R5 low byte pins", pin_out, (8'h3C & 8'hF0) | (8'hC6 & 8'h0F));
      check("R7 forced oe", pin_oe, 8'hFF);
      wr(4'd3, 8'hFF);
      check("R5 full low byte", pin_out, 8'h3C);
   endtask

   task automatic t_addr_high();
      high_byte_sel = 1'b1;
      #1;
      check("R6 high byte", pin_out, 8'h9E);
      bus_cycle(8'h01, 8'h80);
      check("R6 high byte new", pin_out, 8'h80);
      high_byte_sel = 1'b0;
      #1;
      check("R5 low after switch", pin_out, 8'h01);
   endtask

   task automatic t_latch_hold();
      @(negedge clk);
      ad_bus = 8'hE7;
      @(negedge clk);
      check("R8 hold while ale low", pin_out, 8'h01);
      ale = 1'b1; ad_bus = 8'h66;
      @(negedge clk);
      ad_bus = 8'h77;
      @(negedge clk);
      check("R8 hold while ale high", pin_out, 8'h01);
      ale = 1'b0; ad_bus = 8'hB4;
      @(negedge clk);
      check("R8 capture at fall", pin_out, 8'hB4);
      ad_bus = 8'h00;
      @(negedge clk);
      check("R8 keep after fall", pin_out, 8'hB4);
   endtask

   task automatic t_restore();
      logic [7:0] d;
      wr(4'd3, 8'h00);
      check("R9 data restored", pin_out, 8'hC6);
      check("R9 dir restored", pin_oe, 8'h0F);
      rd(4'd0, d); check("R9 data reg kept", d, 8'hC6);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_regs();
      t_gpio();
      t_addr_low();
      t_addr_high();
      t_latch_hold();
      t_restore();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end
endmodule